// File: doc/BRIEF.md
# Byte-Wide Erasable Programmable Memory Mode Core

A synchronous, cycle-based model of a byte-wide memory that can only be written by clearing bits and that is restored by a bulk erase. A 15-bit address selects a byte. Data travels on a split bidirectional path: `din_i` carries data in, and `dout_o` together with the drive enable `doe_o` carries data out. Two active-low selects (`ce_n_i` for the device, `oe_n_i` for the output) work with two boolean voltage flags: `vpp_hi_i` marks the raised programming supply and `a9_id_i` marks the identifier level on address line 9. Together these choose one of several modes. The modes are plain read, output off, standby, bit-clearing program, verify, program inhibit and a fixed two-byte identifier readout.

The depth of the array is a power-of-two parameter, so a test build can use a small array. The default is kept to a few thousand bytes so the array stays small in every build, and the port is still 15 bits wide. Addresses wrap modulo the depth. The block runs a bulk erase after reset and whenever `erase_i` is raised. While the erase runs it reports busy and ignores all accesses. Every output is registered, so the outputs show the result of the inputs sampled at the previous rising clock edge.

Top module: `byte_rom_emu`

## Requirements
- R1: Releasing reset starts an erase. `busy_o` stays high for exactly DEPTH clock cycles, and during that time `doe_o` is 0.
- R2: When an erase finishes, every location reads 0xFF.
- R3: Read mode is `ce_n_i`=0, `oe_n_i`=0, `vpp_hi_i`=0 and `a9_id_i`=0. In this mode, the cycle after sampling, `doe_o`=1 and `dout_o` holds the byte stored at the address.
- R4: With `vpp_hi_i`=0 and either select high (`ce_n_i`=1 or `oe_n_i`=1), the next cycle shows `doe_o`=0. Whenever `doe_o` is 0, `dout_o` is 0x00.
- R5: With `vpp_hi_i`=1 and `oe_n_i`=1, a change of `ce_n_i` from 1 to 0 between two consecutive clock samples makes the stored byte equal to the old byte AND `din_i`. Holding `ce_n_i` low afterwards writes nothing more, even if `din_i` changes.
- R6: Verify mode is `vpp_hi_i`=1, `ce_n_i`=1 and `oe_n_i`=0. In this mode the stored byte is driven with `doe_o`=1. Every other combination of the selects with `vpp_hi_i`=1 gives `doe_o`=0.
- R7: A falling edge of `ce_n_i` does not change the array when `oe_n_i`=0 or when `vpp_hi_i`=0.
- R8: Identifier mode is `a9_id_i`=1 with `ce_n_i`=0, `oe_n_i`=0 and `vpp_hi_i`=0. In this mode `dout_o` is 0x20 when address bit 0 is 0 and 0x8D when it is 1, and `doe_o`=1.
- R9: `erase_i`=1 sampled while idle raises `busy_o` from the next cycle for DEPTH cycles. `erase_i` sampled while busy does not lengthen the erase.
- R10: While `busy_o` is high, `doe_o` is 0 and program pulses leave the array unchanged.
- R11: The array index is the address modulo DEPTH, so addresses that differ by a multiple of DEPTH reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; starts an erase when released |
| addr_i | input | 15 | Byte address |
| din_i | input | 8 | Data to program |
| ce_n_i | input | 1 | Device select, active low; falling edge is the program pulse |
| oe_n_i | input | 1 | Output select, active low |
| vpp_hi_i | input | 1 | Programming supply raised |
| a9_id_i | input | 1 | Identifier level present on address line 9 |
| erase_i | input | 1 | Start a bulk erase |
| dout_o | output | 8 | Registered read data, 0x00 when not driven |
| doe_o | output | 1 | Output drive enable |
| busy_o | output | 1 | Erase in progress |

## Verification
A wrong select-history bit shows up one cycle after a pulse. Either a byte loses extra bits because a held pulse wrote twice, or a byte keeps bits because a pulse was missed. A read or verify of that byte on the very next cycle exposes either fault. A wrong erase pointer or terminal count shows up two ways. The busy window has the wrong length, which a counter at the port catches on the cycle busy falls. Or some location reads other than 0xFF in the full sweep that follows. A wrong mode decode appears at `doe_o` on the cycle after the controls are applied.

// File: rtl/byte_rom_pkg.sv
package byte_rom_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] ID_LOW_BYTE  = 8'h20;
    localparam logic [BYTE_W-1:0] ID_HIGH_BYTE = 8'h8D;
    localparam logic [BYTE_W-1:0] ERASED_BYTE  = 8'hFF;

    typedef enum logic [3:0] {
        MODE_BUSY     = 4'd0,
        MODE_STANDBY  = 4'd1,
        MODE_OUT_OFF  = 4'd2,
        MODE_READ     = 4'd3,
        MODE_IDENT    = 4'd4,
        MODE_PROGRAM  = 4'd5,
        MODE_VERIFY   = 4'd6,
        MODE_INHIBIT  = 4'd7,
        MODE_CLASH    = 4'd8
    } mode_e;

    function automatic logic mode_drives(mode_e m);
        return (m == MODE_READ) || (m == MODE_IDENT) || (m == MODE_VERIFY);
    endfunction

endpackage

// File: rtl/byte_rom_decode.sv
module byte_rom_decode
    import byte_rom_pkg::*;
(
    input  logic  busy_i,
    input  logic  vpp_hi_i,
    input  logic  ce_n_i,
    input  logic  oe_n_i,
    input  logic  a9_id_i,
    output mode_e mode_o
);

    always_comb begin
        if (busy_i) begin
            mode_o = MODE_BUSY;
        end else if (vpp_hi_i) begin
            case ({ce_n_i, oe_n_i})
                2'b01:   mode_o = MODE_PROGRAM;
                2'b10:   mode_o = MODE_VERIFY;
                2'b11:   mode_o = MODE_INHIBIT;
                default: mode_o = MODE_CLASH;
            endcase
        end else if (ce_n_i) begin
            mode_o = MODE_STANDBY;
        end else if (oe_n_i) begin
            mode_o = MODE_OUT_OFF;
        end else if (a9_id_i) begin
            mode_o = MODE_IDENT;
        end else begin
            mode_o = MODE_READ;
        end
    end

endmodule

// File: rtl/byte_rom_ctrl.sv
module byte_rom_ctrl
    import byte_rom_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode_i,
    input  logic              ce_n_i,
    input  logic              erase_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [BYTE_W-1:0] din_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [BYTE_W-1:0] wr_data_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] ptr;
        logic             ce_prev;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  pulse_fall;

    assign pulse_fall = st_q.ce_prev && !ce_n_i;

    always_comb begin
        st_d         = st_q;
        st_d.ce_prev = ce_n_i;
        wr_en_o      = 1'b0;
        wr_idx_o     = idx_i;
        wr_data_o    = rd_data_i & din_i;
        if (st_q.busy) begin
            wr_en_o   = 1'b1;
            wr_idx_o  = st_q.ptr;
            wr_data_o = ERASED_BYTE;
            if (st_q.ptr == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.ptr  = '0;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end else if (erase_i) begin
            st_d.busy = 1'b1;
            st_d.ptr  = '0;
        end else if (mode_i == MODE_PROGRAM && pulse_fall) begin
            wr_en_o = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy    <= 1'b1;
            st_q.ptr     <= '0;
            st_q.ce_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;

endmodule

// File: rtl/byte_rom_store.sv
module byte_rom_store
    import byte_rom_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [BYTE_W-1:0] rd_data_o
);

    logic [BYTE_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            cells_q[wr_idx_i] <= wr_data_i;
        end
    end

    assign rd_data_o = cells_q[rd_idx_i];

endmodule

// File: rtl/byte_rom_outreg.sv
module byte_rom_outreg
    import byte_rom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode_i,
    input  logic              sel_odd_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [BYTE_W-1:0] dout_o,
    output logic              doe_o
);

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              drive;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d.drive = mode_drives(mode_i);
        case (mode_i)
            MODE_IDENT:  out_d.data = sel_odd_i ? ID_HIGH_BYTE : ID_LOW_BYTE;
            MODE_READ,
            MODE_VERIFY: out_d.data = rd_data_i;
            default:     out_d.data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dout_o = out_q.data;
    assign doe_o  = out_q.drive;

endmodule

// File: rtl/byte_rom_emu.sv
module byte_rom_emu
    import byte_rom_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DEPTH  = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        din_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              vpp_hi_i,
    input  logic              a9_id_i,
    input  logic              erase_i,
    output logic [7:0]        dout_o,
    output logic              doe_o,
    output logic              busy_o
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] rd_data;
    logic [BYTE_W-1:0] wr_data;
    logic [IDX_W-1:0]  wr_idx;
    logic              wr_en;
    logic              busy;
    mode_e             mode;

    assign idx = addr_i[IDX_W-1:0];

    byte_rom_decode u_decode (
        .busy_i   (busy),
        .vpp_hi_i (vpp_hi_i),
        .ce_n_i   (ce_n_i),
        .oe_n_i   (oe_n_i),
        .a9_id_i  (a9_id_i),
        .mode_o   (mode)
    );

    byte_rom_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode),
        .ce_n_i    (ce_n_i),
        .erase_i   (erase_i),
        .idx_i     (idx),
        .din_i     (din_i),
        .rd_data_i (rd_data),
        .busy_o    (busy),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data)
    );

    byte_rom_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .rd_idx_i  (idx),
        .rd_data_o (rd_data)
    );

    byte_rom_outreg u_outreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode),
        .sel_odd_i (addr_i[0]),
        .rd_data_i (rd_data),
        .dout_o    (dout_o),
        .doe_o     (doe_o)
    );

    assign busy_o = busy;

endmodule

// File: rtl/byte_rom_emu_chk.sv
module byte_rom_emu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       addr_lsb,
    input logic       ce_n_i,
    input logic       oe_n_i,
    input logic       vpp_hi_i,
    input logic       a9_id_i,
    input logic       erase_i,
    input logic [7:0] dout_o,
    input logic       doe_o,
    input logic       busy_o
);

    assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !doe_o);

    assert_read_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !vpp_hi_i && !ce_n_i && !oe_n_i && !a9_id_i) |=> doe_o);

    assert_select_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpp_hi_i && (ce_n_i || oe_n_i)) |=> !doe_o);

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !doe_o |-> (dout_o == 8'h00));

    assert_verify_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && vpp_hi_i && ce_n_i && !oe_n_i) |=> doe_o);

    assert_high_supply_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi_i && !(ce_n_i && !oe_n_i)) |=> !doe_o);

    assert_ident_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !vpp_hi_i && !ce_n_i && !oe_n_i && a9_id_i && !addr_lsb)
        |=> (doe_o && dout_o == 8'h20));

    assert_ident_odd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !vpp_hi_i && !ce_n_i && !oe_n_i && a9_id_i && addr_lsb)
        |=> (doe_o && dout_o == 8'h8D));

    assert_erase_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_i && !busy_o) |=> busy_o);

endmodule

bind byte_rom_emu byte_rom_emu_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_lsb (addr_i[0]),
    .ce_n_i   (ce_n_i),
    .oe_n_i   (oe_n_i),
    .vpp_hi_i (vpp_hi_i),
    .a9_id_i  (a9_id_i),
    .erase_i  (erase_i),
    .dout_o   (dout_o),
    .doe_o    (doe_o),
    .busy_o   (busy_o)
);

// File: tb/byte_rom_emu_bench.sv
module byte_rom_emu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 15;
    localparam int DEPTH      = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [7:0]        din_i = '0;
    logic              ce_n_i = 1'b1;
    logic              oe_n_i = 1'b1;
    logic              vpp_hi_i = 1'b0;
    logic              a9_id_i = 1'b0;
    logic              erase_i = 1'b0;
    logic [7:0]        dout_o;
    logic              doe_o;
    logic              busy_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [7:0] expect_mem [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_rom_emu #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_byte_rom_emu (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .din_i(din_i),
        .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .vpp_hi_i(vpp_hi_i),
        .a9_id_i(a9_id_i), .erase_i(erase_i), .dout_o(dout_o),
        .doe_o(doe_o), .busy_o(busy_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // apply inputs just after a falling edge, return after the next falling edge
    task automatic cyc(input logic ce, input logic oe, input logic vpp, input logic a9,
                       input int addr, input logic [7:0] din, input logic er);
        ce_n_i = ce; oe_n_i = oe; vpp_hi_i = vpp; a9_id_i = a9;
        addr_i = ADDR_W'(addr); din_i = din; erase_i = er;
        @(negedge clk);
    endtask

    task automatic read_expect(input int addr, input string tag);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, addr, 8'h00, 1'b0);
        check(doe_o == 1'b1, tag, doe_o, 1);
        check(dout_o == expect_mem[addr % DEPTH], tag, dout_o, expect_mem[addr % DEPTH]);
    endtask

    task automatic pulse(input int addr, input logic [7:0] din, input logic oe, input logic vpp);
        cyc(1'b1, oe, vpp, 1'b0, addr, din, 1'b0);
        cyc(1'b0, oe, vpp, 1'b0, addr, din, 1'b0);
        check(doe_o == 1'b0, "R6 no drive during pulse", doe_o, 0);
        cyc(1'b0, oe, vpp, 1'b0, addr, 8'h00, 1'b0);
        cyc(1'b1, 1'b1, vpp, 1'b0, addr, 8'h00, 1'b0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(doe_o == 1'b0, "R1 reset doe", doe_o, 0);
        check(busy_o == 1'b1, "R1 reset busy", busy_o, 1);
        rst_n = 1'b1;
        n = 0;
        while (busy_o) begin
            cyc(1'b0, 1'b0, 1'b0, 1'b0, n, 8'h00, 1'b0);
            check(doe_o == 1'b0, "R1 quiet during erase", doe_o, 0);
            n++;
        end
        check(n == DEPTH, "R1 erase length", n, DEPTH);

        // R2 R3: erased contents
        for (int a = 0; a < DEPTH; a++) expect_mem[a] = 8'hFF;
        for (int a = 0; a < DEPTH; a++) read_expect(a, "R2 erased read");

        // R4: select combinations that keep outputs off
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 3, 8'h00, 1'b0);
        check(doe_o == 1'b0 && dout_o == 8'h00, "R4 standby", {doe_o, dout_o}, 0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 3, 8'h00, 1'b0);
        check(doe_o == 1'b0 && dout_o == 8'h00, "R4 output off", {doe_o, dout_o}, 0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 3, 8'h00, 1'b0);
        check(doe_o == 1'b0, "R4 identifier with output off", doe_o, 0);

        // R5: first programming pass, long pulses with changed din
        for (int a = 0; a < DEPTH; a++) begin
            logic [7:0] f;
            f = 8'((a * 37 + 5) & 255);
            pulse(a, f, 1'b1, 1'b1);
            expect_mem[a] = expect_mem[a] & f;
        end
        // R6: verify sweep
        for (int a = 0; a < DEPTH; a++) begin
            cyc(1'b1, 1'b0, 1'b1, 1'b0, a, 8'h00, 1'b0);
            check(doe_o == 1'b1 && dout_o == expect_mem[a], "R6 verify",
                  {doe_o, dout_o}, {1'b1, expect_mem[a]});
        end
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 0, 8'h00, 1'b0);
        check(doe_o == 1'b0, "R6 inhibit off", doe_o, 0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 0, 8'h00, 1'b0);
        check(doe_o == 1'b0, "R6 both selects low off", doe_o, 0);

        // R5: second pass ANDs into stored bytes; R11 via aliased addresses
        for (int a = 0; a < DEPTH; a++) begin
            logic [7:0] g;
            g = 8'(~((a * 13) & 255));
            pulse(a + DEPTH * (a % 5), g, 1'b1, 1'b1);
            expect_mem[a] = expect_mem[a] & g;
        end
        for (int a = 0; a < DEPTH; a++) read_expect(a, "R5 second pass");
        for (int a = 0; a < DEPTH; a++) read_expect(a + DEPTH * 7, "R11 alias read");

        // R7: falling edges without the program conditions
        for (int a = 0; a < DEPTH; a++) begin
            pulse(a, 8'h00, 1'b0, 1'b1);
            pulse(a, 8'h00, 1'b1, 1'b0);
        end
        for (int a = 0; a < DEPTH; a++) read_expect(a, "R7 unchanged");

        // R8: identifier bytes
        for (int a = 0; a < 8; a++) begin
            int ad;
            ad = a * 4099;
            cyc(1'b0, 1'b0, 1'b0, 1'b1, ad, 8'h00, 1'b0);
            check(doe_o == 1'b1 && dout_o == ((ad % 2 == 1) ? 8'h8D : 8'h20),
                  "R8 identifier", dout_o, (ad % 2 == 1) ? 8'h8D : 8'h20);
        end

        // R9 R10: erase with accesses and a program attempt while busy
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 0, 8'h00, 1'b1);
        check(busy_o == 1'b1, "R9 erase starts", busy_o, 1);
        n = 0;
        while (busy_o) begin
            case (n)
                0: cyc(1'b0, 1'b0, 1'b0, 1'b0, 1, 8'h00, 1'b1);
                1: cyc(1'b1, 1'b1, 1'b1, 1'b0, 2, 8'h00, 1'b0);
                2: cyc(1'b0, 1'b1, 1'b1, 1'b0, 2, 8'h00, 1'b0);
                default: cyc(1'b0, 1'b0, 1'b0, 1'b0, n, 8'h00, 1'b0);
            endcase
            check(doe_o == 1'b0, "R10 quiet while busy", doe_o, 0);
            n++;
        end
        check(n == DEPTH, "R9 erase length", n, DEPTH);
        for (int a = 0; a < DEPTH; a++) expect_mem[a] = 8'hFF;
        for (int a = 0; a < DEPTH; a++) read_expect(a, "R9 R10 erased again");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule